// File: doc/BRIEF.md
# Receive Auto-Acknowledge Controller

This controller runs the receive side of a low-rate wireless MAC that answers frames on its own. It sits in a listen state until the PHY receiver reports a frame length. A non-zero length moves it into a busy state, where it reads the frame control and sequence number bytes from the incoming byte stream. It also takes the verdicts of an external address filter and of an external FCS checker. From these it raises an address-match interrupt and an end-of-reception interrupt.

When the received frame asks for an acknowledgment, is of a type that may be acknowledged and passes the filter with a good FCS, the controller builds the ACK header and starts the transmitter. The start comes either after a turnaround counted in symbol ticks or, in slotted operation, on a rising edge of an external trigger. A three-valued status field tracks each transaction.

Top module: `rx_autoack_ctrl`

## Requirements
- R1: After reset, `trac_status` is 7 and `irq_addr_match`, `irq_rx_done` and `ack_start` are low.
- R2: In the listen state, `phr_valid` with a non-zero `phr_len` starts a transaction: one cycle later `trac_status` reads 7 (INVALID). A zero length is ignored, and the bytes, filter result and `rx_end` that follow raise no interrupt.
- R3: While busy, `filt_valid` with `filt_pass` high gives a one-cycle `irq_addr_match` in the next cycle. This also holds when it coincides with `rx_end`.
- R4: `rx_end` while busy gives a one-cycle `irq_rx_done` in the next cycle when the filter passed and `fcs_ok` is high, or when `cfg_promisc` is high. Otherwise no interrupt is raised.
- R5: An ACK is needed only when bit 5 of the first frame control byte is set, the frame type (bits 2:0 of that byte) is 1 (data) or 3 (command), the filter passed and `fcs_ok` is high. Types 0 and 2 never get an ACK.
- R6: With `cfg_short_ta` low, `ack_start` pulses for one cycle in the cycle after the 12th `sym_tick` that follows `rx_end`. With `cfg_short_ta` high, it pulses after the 2nd tick.
- R7: With `cfg_slotted` high, symbol ticks are ignored. `ack_start` pulses in the cycle after `slot_trig` is first seen high following a low sample.
- R8: From the cycle after `rx_end`, `ack_fc` holds 0x0002 with bit 4 set to `cfg_frame_pend`. `ack_seq` holds the third received byte.
- R9: With `cfg_no_ack` high, no ACK is started even when one is requested.
- R10: `trac_status` reads 2 from `rx_end` until `ack_start`, and 0 from `ack_start` on. A frame that completes with no ACK needed reads 0 if it raised `irq_rx_done`, and otherwise stays at 7.
- R11: After an ACK is started, or after a frame that needs no ACK, the controller is back in the listen state and accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phr_valid | input | 1 | Frame length valid pulse from the PHY |
| phr_len | input | 7 | Frame length in bytes |
| rx_byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Last symbol of the frame received |
| filt_valid | input | 1 | Address filter verdict strobe |
| filt_pass | input | 1 | Address filter verdict |
| fcs_ok | input | 1 | FCS good, sampled with `rx_end` |
| sym_tick | input | 1 | One pulse per symbol period |
| slot_trig | input | 1 | Slotted-mode ACK trigger |
| cfg_promisc | input | 1 | Report every frame at its end |
| cfg_short_ta | input | 1 | Use the 2-symbol turnaround |
| cfg_frame_pend | input | 1 | Frame-pending bit for the ACK |
| cfg_no_ack | input | 1 | Never send an ACK |
| cfg_slotted | input | 1 | Start the ACK from `slot_trig` |
| irq_addr_match | output | 1 | Address match interrupt pulse |
| irq_rx_done | output | 1 | End-of-reception interrupt pulse |
| ack_start | output | 1 | Start-of-ACK pulse to the transmitter |
| ack_fc | output | 16 | ACK frame control |
| ack_seq | output | 8 | ACK sequence number |
| trac_status | output | 3 | Transaction status (0, 2 or 7) |

## Verification
The address-match and end-of-reception interrupts can fall in the same cycle when the filter verdict arrives together with `rx_end`. This is also the last moment at which the filter verdict can still decide the ACK. The bench drives `filt_valid` and `rx_end` on the same edge for an ACK-requesting data frame. It then requires both interrupts in the next cycle, followed by an ACK on the 12th symbol tick. That shows the late verdict counted for both the interrupt and the ACK decision.

// File: rtl/rxaa_pkg.sv
package rxaa_pkg;
  typedef enum logic [1:0] {
    ST_LISTEN = 2'd0,
    ST_BUSY   = 2'd1,
    ST_WAIT   = 2'd2
  } rxaa_state_e;

  localparam logic [2:0] TRAC_SUCCESS = 3'd0;
  localparam logic [2:0] TRAC_WAIT    = 3'd2;
  localparam logic [2:0] TRAC_INVALID = 3'd7;

  localparam logic [2:0] FTYPE_DATA = 3'd1;
  localparam logic [2:0] FTYPE_ACK  = 3'd2;
  localparam logic [2:0] FTYPE_CMD  = 3'd3;
  localparam int         ACK_RQ_BIT = 5;
  localparam int         PEND_BIT   = 4;
endpackage

// File: rtl/rxaa_hdr_parse.sv
module rxaa_hdr_parse #(
  parameter int BYTE_W  = 8,
  parameter int SEQ_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [BYTE_W-1:0] fc_lo,
  output logic [BYTE_W-1:0] seq
);
  localparam int IDX_W   = $clog2(SEQ_IDX + 2);
  localparam int IDX_MAX = SEQ_IDX + 1;

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] fc_q, fc_d, seq_q, seq_d;

  always_comb begin
    idx_d = idx_q;
    fc_d  = fc_q;
    seq_d = seq_q;
    if (clr) begin
      idx_d = '0;
    end else if (byte_valid && (idx_q != IDX_W'(IDX_MAX))) begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == '0)                 fc_d  = byte_data;
      if (idx_q == IDX_W'(SEQ_IDX))    seq_d = byte_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      fc_q  <= '0;
      seq_q <= '0;
    end else begin
      idx_q <= idx_d;
      fc_q  <= fc_d;
      seq_q <= seq_d;
    end
  end

  assign fc_lo = fc_q;
  assign seq   = seq_q;
endmodule

// File: rtl/rxaa_turn_timer.sv
module rxaa_turn_timer #(
  parameter int TURN_LONG  = 12,
  parameter int TURN_SHORT = 2,
  parameter int CNT_W      = $clog2(TURN_LONG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic short_sel,
  input  logic slotted,
  input  logic sym_tick,
  input  logic trig_in,
  output logic fire
);
  logic             armed_q, armed_d;
  logic             slot_q, slot_d;
  logic             trig_q;
  logic [CNT_W-1:0] lim_q, lim_d, cnt_q, cnt_d;
  logic             trig_edge, count_done;

  assign trig_edge  = trig_in & ~trig_q;
  assign count_done = sym_tick && ((cnt_q + CNT_W'(1)) == lim_q);
  assign fire       = armed_q & (slot_q ? trig_edge : count_done);

  always_comb begin
    armed_d = armed_q;
    slot_d  = slot_q;
    lim_d   = lim_q;
    cnt_d   = cnt_q;
    if (start) begin
      armed_d = 1'b1;
      slot_d  = slotted;
      lim_d   = short_sel ? CNT_W'(TURN_SHORT) : CNT_W'(TURN_LONG);
      cnt_d   = '0;
    end else if (armed_q) begin
      if (fire)                      armed_d = 1'b0;
      else if (sym_tick && !slot_q)  cnt_d   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      slot_q  <= 1'b0;
      lim_q   <= '0;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      slot_q  <= slot_d;
      lim_q   <= lim_d;
      cnt_q   <= cnt_d;
      trig_q  <= trig_in;
    end
  end
endmodule

// File: rtl/rx_autoack_ctrl.sv
module rx_autoack_ctrl
  import rxaa_pkg::*;
#(
  parameter int LEN_W      = 7,
  parameter int BYTE_W     = 8,
  parameter int TURN_LONG  = 12,
  parameter int TURN_SHORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phr_valid,
  input  logic [LEN_W-1:0]  phr_len,
  input  logic              rx_byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_end,
  input  logic              filt_valid,
  input  logic              filt_pass,
  input  logic              fcs_ok,
  input  logic              sym_tick,
  input  logic              slot_trig,
  input  logic              cfg_promisc,
  input  logic              cfg_short_ta,
  input  logic              cfg_frame_pend,
  input  logic              cfg_no_ack,
  input  logic              cfg_slotted,
  output logic              irq_addr_match,
  output logic              irq_rx_done,
  output logic              ack_start,
  output logic [2*BYTE_W-1:0] ack_fc,
  output logic [BYTE_W-1:0] ack_seq,
  output logic [2:0]        trac_status
);
  localparam int CNT_W = $clog2(TURN_LONG + 1);
  localparam int FC_W  = 2 * BYTE_W;

  rxaa_state_e       state_q, state_d;
  logic [2:0]        status_q, status_d;
  logic              am_q, am_d, done_q, done_d, ack_q, ack_d;
  logic              filt_ok_q, filt_ok_d;
  logic [FC_W-1:0]   fc_q, fc_d;
  logic [BYTE_W-1:0] seq_q, seq_d;

  logic              in_listen, in_busy, frame_start, filt_hit, filt_ok_now;
  logic              type_ok, need_ack, accept, end_now, tmr_fire;
  logic [BYTE_W-1:0] hdr_fc, hdr_seq;
  logic [FC_W-1:0]   fc_build;

  assign in_listen   = (state_q == ST_LISTEN);
  assign in_busy     = (state_q == ST_BUSY);
  assign frame_start = in_listen & phr_valid & (phr_len != '0);
  assign filt_hit    = in_busy & filt_valid & filt_pass;
  assign filt_ok_now = filt_ok_q | filt_hit;
  assign type_ok     = (hdr_fc[2:0] == FTYPE_DATA) || (hdr_fc[2:0] == FTYPE_CMD);
  assign need_ack    = hdr_fc[ACK_RQ_BIT] & type_ok & filt_ok_now & fcs_ok & ~cfg_no_ack;
  assign accept      = (filt_ok_now & fcs_ok) | cfg_promisc;
  assign end_now     = in_busy & rx_end;

  always_comb begin
    fc_build           = '0;
    fc_build[2:0]      = FTYPE_ACK;
    fc_build[PEND_BIT] = cfg_frame_pend;
  end

  rxaa_hdr_parse #(.BYTE_W(BYTE_W), .SEQ_IDX(2)) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (frame_start),
    .byte_valid (rx_byte_valid & in_busy),
    .byte_data  (rx_byte),
    .fc_lo      (hdr_fc),
    .seq        (hdr_seq)
  );

  rxaa_turn_timer #(.TURN_LONG(TURN_LONG), .TURN_SHORT(TURN_SHORT), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (end_now & need_ack),
    .short_sel (cfg_short_ta),
    .slotted   (cfg_slotted),
    .sym_tick  (sym_tick),
    .trig_in   (slot_trig),
    .fire      (tmr_fire)
  );

  always_comb begin
    state_d   = state_q;
    status_d  = status_q;
    am_d      = filt_hit;
    done_d    = end_now & accept;
    ack_d     = 1'b0;
    filt_ok_d = filt_ok_q;
    fc_d      = fc_q;
    seq_d     = seq_q;
    unique case (state_q)
      ST_LISTEN: begin
        if (frame_start) begin
          state_d   = ST_BUSY;
          status_d  = TRAC_INVALID;
          filt_ok_d = 1'b0;
        end
      end
      ST_BUSY: begin
        if (filt_hit) filt_ok_d = 1'b1;
        if (rx_end) begin
          if (need_ack) begin
            state_d  = ST_WAIT;
            status_d = TRAC_WAIT;
            fc_d     = fc_build;
            seq_d    = hdr_seq;
          end else begin
            state_d  = ST_LISTEN;
            if (accept) status_d = TRAC_SUCCESS;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_fire) begin
          ack_d    = 1'b1;
          status_d = TRAC_SUCCESS;
          state_d  = ST_LISTEN;
        end
      end
      default: state_d = ST_LISTEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LISTEN;
      status_q  <= TRAC_INVALID;
      am_q      <= 1'b0;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
      filt_ok_q <= 1'b0;
      fc_q      <= '0;
      seq_q     <= '0;
    end else begin
      state_q   <= state_d;
      status_q  <= status_d;
      am_q      <= am_d;
      done_q    <= done_d;
      ack_q     <= ack_d;
      filt_ok_q <= filt_ok_d;
      fc_q      <= fc_d;
      seq_q     <= seq_d;
    end
  end

  assign irq_addr_match = am_q;
  assign irq_rx_done    = done_q;
  assign ack_start      = ack_q;
  assign ack_fc         = fc_q;
  assign ack_seq        = seq_q;
  assign trac_status    = status_q;
endmodule

// File: rtl/rxaa_ctrl_chk.sv
module rxaa_ctrl_chk #(
  parameter int LEN_W  = 7,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_listen,
  input logic              phr_valid,
  input logic [LEN_W-1:0]  phr_len,
  input logic              rx_end,
  input logic              filt_valid,
  input logic              filt_pass,
  input logic              irq_addr_match,
  input logic              irq_rx_done,
  input logic              ack_start,
  input logic [BYTE_W-1:0] ack_seq,
  input logic [2:0]        trac_status
);
  assert_start_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_listen && phr_valid && (phr_len != '0)) |=> (trac_status == 3'd7));

  assert_am_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_addr_match |-> $past(filt_valid && filt_pass));

  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_done |-> $past(rx_end));

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> !ack_start);

  assert_seq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> $stable(ack_seq));

  assert_ack_after_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> ($past(trac_status) == 3'd2));

  assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trac_status == 3'd0) || (trac_status == 3'd2) || (trac_status == 3'd7));
endmodule

bind rx_autoack_ctrl rxaa_ctrl_chk #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_listen      (in_listen),
  .phr_valid      (phr_valid),
  .phr_len        (phr_len),
  .rx_end         (rx_end),
  .filt_valid     (filt_valid),
  .filt_pass      (filt_pass),
  .irq_addr_match (irq_addr_match),
  .irq_rx_done    (irq_rx_done),
  .ack_start      (ack_start),
  .ack_seq        (ack_seq),
  .trac_status    (trac_status)
);

// File: tb/rx_autoack_ctrl_tb_top.sv
module rx_autoack_ctrl_tb_top;
  logic clk, rst_n;
  logic phr_valid, rx_byte_valid, rx_end, filt_valid, filt_pass, fcs_ok;
  logic sym_tick, slot_trig;
  logic cfg_promisc, cfg_short_ta, cfg_frame_pend, cfg_no_ack, cfg_slotted;
  logic [6:0]  phr_len;
  logic [7:0]  rx_byte;
  logic        irq_addr_match, irq_rx_done, ack_start;
  logic [15:0] ack_fc;
  logic [7:0]  ack_seq;
  logic [2:0]  trac_status;
  int n_chk = 0;
  int n_err = 0;

  rx_autoack_ctrl dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_frame(input logic [6:0] len, input logic [7:0] fc0, input logic [7:0] sq,
                          input bit fpass, input bit fok, input bit same_cycle, input bit exp_done);
    logic [7:0] b [5];
    b = '{fc0, 8'h00, sq, 8'hAB, 8'hCD};
    @(negedge clk); phr_valid = 1'b1; phr_len = len;
    @(negedge clk); phr_valid = 1'b0;
    if (len != 0) chk("R2 status INVALID at start", trac_status, 7);
    for (int i = 0; i < 5; i++) begin
      rx_byte_valid = 1'b1; rx_byte = b[i];
      @(negedge clk);
    end
    rx_byte_valid = 1'b0;
    if (!same_cycle) begin
      filt_valid = 1'b1; filt_pass = fpass;
      @(negedge clk); filt_valid = 1'b0;
      chk("R3 address match irq", irq_addr_match, (len != 0) && fpass);
    end
    rx_end = 1'b1; fcs_ok = fok;
    if (same_cycle) begin filt_valid = 1'b1; filt_pass = fpass; end
    @(negedge clk); rx_end = 1'b0; filt_valid = 1'b0;
    if (same_cycle) chk("R3 address match irq with rx_end", irq_addr_match, fpass);
    chk("R4 end of reception irq", irq_rx_done, exp_done);
    @(negedge clk);
    chk("R4 end irq single pulse", irq_rx_done, 0);
  endtask

  task automatic ticks(input string req, input int n, input int fire_at);
    for (int k = 1; k <= n; k++) begin
      sym_tick = 1'b1;
      @(negedge clk); sym_tick = 1'b0;
      chk(req, ack_start, (k == fire_at));
      if (fire_at == 0 || k < fire_at) chk("R10 status while waiting", trac_status, (fire_at == 0) ? int'(trac_status) : 2);
    end
  endtask

  task automatic t_reset();
    chk("R1 status after reset", trac_status, 7);
    chk("R1 addr irq after reset", irq_addr_match, 0);
    chk("R1 done irq after reset", irq_rx_done, 0);
    chk("R1 ack after reset", ack_start, 0);
  endtask

  task automatic t_zero_len();
    do_frame(7'd0, 8'h21, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 zero length keeps status", trac_status, 7);
  endtask

  task automatic t_long_ack();
    do_frame(7'd5, 8'h21, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R10 status WAIT after end", trac_status, 2);
    chk("R8 ack fc no pending", ack_fc, 16'h0002);
    chk("R8 ack seq copied", ack_seq, 8'h5A);
    ticks("R6 long turnaround", 13, 12);
    chk("R10 status SUCCESS after ack", trac_status, 0);
  endtask

  task automatic t_short_pend();
    cfg_short_ta = 1'b1; cfg_frame_pend = 1'b1;
    do_frame(7'd5, 8'h23, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 ack fc pending bit4", ack_fc, 16'h0012);
    chk("R8 ack seq command frame", ack_seq, 8'h11);
    ticks("R6 short turnaround", 4, 2);
    cfg_short_ta = 1'b0; cfg_frame_pend = 1'b0;
  endtask

  task automatic t_slotted();
    cfg_slotted = 1'b1;
    do_frame(7'd5, 8'h21, 8'h77, 1'b1, 1'b1, 1'b0, 1'b1);
    ticks("R7 ticks ignored when slotted", 14, 0);
    chk("R7 still waiting", trac_status, 2);
    slot_trig = 1'b1;
    @(negedge clk);
    chk("R7 ack on trigger edge", ack_start, 1);
    chk("R10 success on slotted ack", trac_status, 0);
    @(negedge clk);
    chk("R7 single pulse with trigger held", ack_start, 0);
    slot_trig = 1'b0; cfg_slotted = 1'b0;
    do_frame(7'd5, 8'h01, 8'h02, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R11 next frame accepted after ack", trac_status, 0);
  endtask

  task automatic t_no_ack_cases();
    do_frame(7'd5, 8'h20, 8'h03, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R5 beacon gives no wait", trac_status, 0);
    ticks("R5 beacon never acked", 12, 0);
    do_frame(7'd5, 8'h22, 8'h04, 1'b1, 1'b1, 1'b0, 1'b1);
    ticks("R5 ack frame never acked", 12, 0);
    do_frame(7'd5, 8'h01, 8'h05, 1'b1, 1'b1, 1'b0, 1'b1);
    ticks("R5 no request bit", 12, 0);
    chk("R11 back to listen no ack", trac_status, 0);
    do_frame(7'd5, 8'h21, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 bad fcs keeps INVALID", trac_status, 7);
    ticks("R5 bad fcs not acked", 12, 0);
    do_frame(7'd5, 8'h21, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 filter fail no irq", trac_status, 7);
    cfg_promisc = 1'b1;
    do_frame(7'd5, 8'h21, 8'h08, 1'b0, 1'b1, 1'b0, 1'b1);
    ticks("R5 promiscuous filter fail not acked", 12, 0);
    cfg_promisc = 1'b0;
  endtask

  task automatic t_disable();
    cfg_no_ack = 1'b1;
    do_frame(7'd5, 8'h21, 8'h09, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 disabled ack success status", trac_status, 0);
    ticks("R9 ack suppressed", 12, 0);
    cfg_no_ack = 1'b0;
  endtask

  task automatic t_collide();
    do_frame(7'd5, 8'h21, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R5 late filter verdict requests ack", trac_status, 2);
    ticks("R6 ack after coincident verdict", 12, 12);
    chk("R8 seq after coincident verdict", ack_seq, 8'h3C);
  endtask

  initial begin
    rst_n = 1'b0; phr_valid = 1'b0; phr_len = '0; rx_byte_valid = 1'b0; rx_byte = '0;
    rx_end = 1'b0; filt_valid = 1'b0; filt_pass = 1'b0; fcs_ok = 1'b0;
    sym_tick = 1'b0; slot_trig = 1'b0;
    cfg_promisc = 1'b0; cfg_short_ta = 1'b0; cfg_frame_pend = 1'b0;
    cfg_no_ack = 1'b0; cfg_slotted = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_long_ack();
    t_short_pend();
    t_slotted();
    t_no_ack_cases();
    t_disable();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule